// File: doc/BRIEF.md
# Capture Compare PWM Unit

A single timer-attached channel that serves as an input capture, an output compare or a pulse-width modulator. The mode is chosen by a 4-bit field. The unit does not own a timer. It watches a free-running timer value and a period-match pulse that arrive from outside.

In capture modes, an external input pin is brought through a synchronizer. On a chosen edge the unit copies the timer into a capture register. In the rising-edge modes an edge prescaler can be used. In compare modes, the timer is matched against a 16-bit value register. On a match the unit drives the output pin, raises the interrupt flag or requests a timer reset. In PWM mode the value register's low byte and a 2-bit field of the control word together form a 10-bit duty. The duty is measured on a counter made from the timer's low byte and a 2-bit sub-tick count.

Software writes the control word (mode and duty fraction) and the value register through simple write strobes. It clears the sticky interrupt flag with a separate strobe.

Top module: `ccp_unit`

## Requirements
- R1: Mode code 0000, and the unused codes 0001, 0011, 1101, 1110 and 1111, make the unit inactive: the pin is 0 and no capture, match, flag or timer-reset event occurs. Writing any of these codes also clears the capture register, the flag, the edge prescaler and the output latch.
- R2: Code 0101 copies the timer into the capture register on each rising edge of the input. Code 0100 does so on each falling edge. The copy lands two to three cycles after the pin changes.
- R3: Code 0110 captures only on every 4th rising edge, and code 0111 captures only on every 16th rising edge.
- R4: Any control write that changes the mode code restarts the edge prescaler from zero.
- R5: Writing code 1000 forces the pin to 0, and a match then sets it to 1. Writing code 1001 forces the pin to 1, and a match then sets it to 0.
- R6: Under code 0010, each match inverts the pin.
- R7: Under code 1010, a match leaves the pin unchanged and only raises the flag.
- R8: Under code 1011, a match drives both the timer-reset request and the special-event output high for exactly one cycle. No other code produces these pulses.
- R9: A timer that stays equal to the value register counts as one match, not as one match per cycle.
- R10: The flag is set by every capture and by every match in every compare code. It stays set until the clear strobe is given.
- R11: Under code 1100 the pin rises on the period-match pulse and stays high for D cycles. D is the value register's bits [7:0] placed above control bits [5:4]. The mode field is control bits [3:0].
- R12: A duty written during a PWM period takes effect only from the next period-match pulse.
- R13: A duty of 0 keeps the pin low for the whole period. A duty of at least the period length keeps the pin high for the whole period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tmr_val | input | 16 | Free-running timer count |
| tmr_period_hit | input | 1 | One-cycle pulse when the timer wraps at its period |
| ccp_in | input | 1 | Asynchronous capture input pin |
| wr_ctl | input | 1 | Control-word write strobe |
| ctl_wdata | input | 6 | Control word: [3:0] mode, [5:4] duty fraction |
| wr_val | input | 1 | Value-register write strobe |
| val_wdata | input | 16 | Compare value; bits [7:0] are the duty's upper part |
| flag_clr | input | 1 | Clears the interrupt flag |
| ccp_pin | output | 1 | Output pin |
| irq_flag | output | 1 | Sticky interrupt flag |
| tmr_reset_req | output | 1 | One-cycle timer-reset request |
| special_evt | output | 1 | One-cycle special-event pulse |
| cap_val | output | 16 | Capture register |

## Verification
The bench uses the default parameters: a 16-bit timer, an 8+2-bit duty, a two-stage synchronizer, and edge dividers of 4 and 16. With the divider of 16, a full prescaler wrap and its off-by-one neighbour fit in a few hundred cycles. The bench drives the timer's low byte at a quarter of the clock rate, which matches the 2-bit sub-tick. A 64-cycle PWM period can then show a duty of zero, small duties, and a duty that saturates at the 10-bit maximum. The bench also writes a new duty partway through a period to show that the change is deferred.

// File: rtl/ccp_pkg.sv
package ccp_pkg;

    localparam logic [3:0] MODE_OFF      = 4'b0000;
    localparam logic [3:0] MODE_CMP_TOG  = 4'b0010;
    localparam logic [3:0] MODE_CAP_FALL = 4'b0100;
    localparam logic [3:0] MODE_CAP_RISE = 4'b0101;
    localparam logic [3:0] MODE_CAP_R4   = 4'b0110;
    localparam logic [3:0] MODE_CAP_R16  = 4'b0111;
    localparam logic [3:0] MODE_CMP_HI   = 4'b1000;
    localparam logic [3:0] MODE_CMP_LO   = 4'b1001;
    localparam logic [3:0] MODE_CMP_IRQ  = 4'b1010;
    localparam logic [3:0] MODE_CMP_TRIG = 4'b1011;
    localparam logic [3:0] MODE_PWM      = 4'b1100;

    typedef enum logic [1:0] {KIND_OFF, KIND_CAP, KIND_CMP, KIND_PWM} ccp_kind_e;
    typedef enum logic [1:0] {DIV_ONE, DIV_SMALL, DIV_BIG} cap_div_e;
    typedef enum logic [1:0] {ACT_HOLD, ACT_SET, ACT_CLR, ACT_TOG} pin_act_e;

    typedef struct packed {
        ccp_kind_e kind;
        logic      cap_fall;
        cap_div_e  div;
        pin_act_e  act;
        logic      trig;
        logic      init_valid;
        logic      init_lvl;
    } ccp_dec_t;

    function automatic ccp_dec_t decode_mode(input logic [3:0] m);
        ccp_dec_t d;
        d.kind       = KIND_OFF;
        d.cap_fall   = 1'b0;
        d.div        = DIV_ONE;
        d.act        = ACT_HOLD;
        d.trig       = 1'b0;
        d.init_valid = 1'b0;
        d.init_lvl   = 1'b0;
        case (m)
            MODE_CAP_FALL: begin d.kind = KIND_CAP; d.cap_fall = 1'b1; end
            MODE_CAP_RISE: d.kind = KIND_CAP;
            MODE_CAP_R4:   begin d.kind = KIND_CAP; d.div = DIV_SMALL; end
            MODE_CAP_R16:  begin d.kind = KIND_CAP; d.div = DIV_BIG; end
            MODE_CMP_TOG:  begin d.kind = KIND_CMP; d.act = ACT_TOG; end
            MODE_CMP_HI:   begin
                d.kind = KIND_CMP; d.act = ACT_SET;
                d.init_valid = 1'b1; d.init_lvl = 1'b0;
            end
            MODE_CMP_LO:   begin
                d.kind = KIND_CMP; d.act = ACT_CLR;
                d.init_valid = 1'b1; d.init_lvl = 1'b1;
            end
            MODE_CMP_IRQ:  d.kind = KIND_CMP;
            MODE_CMP_TRIG: begin d.kind = KIND_CMP; d.trig = 1'b1; end
            MODE_PWM:      d.kind = KIND_PWM;
            default:       d.kind = KIND_OFF;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/ccp_edge_sync.sv
module ccp_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic rise,
    output logic fall
);
    logic [STAGES:0] sh;

    always_ff @(posedge clk) begin
        if (rst) sh <= '0;
        else     sh <= {sh[STAGES-1:0], din};
    end

    assign rise = sh[STAGES-1] & ~sh[STAGES];
    assign fall = ~sh[STAGES-1] & sh[STAGES];
endmodule

// File: rtl/ccp_capture.sv
module ccp_capture
    import ccp_pkg::*;
#(
    parameter int TMR_W     = 16,
    parameter int SMALL_DIV = 4,
    parameter int BIG_DIV   = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             presc_clr,
    input  logic             wipe,
    input  logic             en,
    input  logic             sel_fall,
    input  cap_div_e         div,
    input  logic             rise,
    input  logic             fall,
    input  logic [TMR_W-1:0] tmr_val,
    output logic [TMR_W-1:0] cap_val,
    output logic             cap_evt
);
    localparam int PS_W = $clog2(BIG_DIV);

    logic [PS_W-1:0] cnt;
    logic [PS_W-1:0] limit;
    logic            edge_hit;

    always_comb begin
        case (div)
            DIV_SMALL: limit = PS_W'(SMALL_DIV - 1);
            DIV_BIG:   limit = PS_W'(BIG_DIV - 1);
            default:   limit = '0;
        endcase
    end

    assign edge_hit = en & (sel_fall ? fall : rise);
    assign cap_evt  = edge_hit & (cnt == limit);

    always_ff @(posedge clk) begin
        if (rst || presc_clr)  cnt <= '0;
        else if (cap_evt)      cnt <= '0;
        else if (edge_hit)     cnt <= cnt + PS_W'(1);
    end

    always_ff @(posedge clk) begin
        if (rst || wipe)  cap_val <= '0;
        else if (cap_evt) cap_val <= tmr_val;
    end
endmodule

// File: rtl/ccp_compare.sv
module ccp_compare
    import ccp_pkg::*;
#(
    parameter int TMR_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wipe,
    input  logic             en,
    input  pin_act_e         act,
    input  logic             trig,
    input  logic             load_init,
    input  logic             init_lvl,
    input  logic [TMR_W-1:0] tmr_val,
    input  logic [TMR_W-1:0] cmp_val,
    output logic             pin,
    output logic             match_evt,
    output logic             trig_q
);
    logic match_now;
    logic match_prev;

    assign match_now = (tmr_val == cmp_val);
    assign match_evt = en & match_now & ~match_prev;

    always_ff @(posedge clk) begin
        if (rst || wipe) match_prev <= 1'b0;
        else             match_prev <= match_now;
    end

    always_ff @(posedge clk) begin
        if (rst || wipe) begin
            pin <= 1'b0;
        end else if (load_init) begin
            pin <= init_lvl;
        end else if (match_evt) begin
            case (act)
                ACT_SET: pin <= 1'b1;
                ACT_CLR: pin <= 1'b0;
                ACT_TOG: pin <= ~pin;
                default: pin <= pin;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst || wipe) trig_q <= 1'b0;
        else             trig_q <= match_evt & trig;
    end
endmodule

// File: rtl/ccp_pwm.sv
module ccp_pwm #(
    parameter int HI_W = 8,
    parameter int LO_W = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 en,
    input  logic                 period_hit,
    input  logic [HI_W-1:0]      tmr_lo,
    input  logic [HI_W+LO_W-1:0] duty_new,
    output logic                 pwm_out
);
    localparam int DW = HI_W + LO_W;

    logic [LO_W-1:0] frac;
    logic [DW-1:0]   duty_q;
    logic [DW-1:0]   count;

    assign count = {tmr_lo, frac};

    always_ff @(posedge clk) begin
        if (rst || period_hit) frac <= '0;
        else                   frac <= frac + LO_W'(1);
    end

    always_ff @(posedge clk) begin
        if (rst)             duty_q <= '0;
        else if (period_hit) duty_q <= duty_new;
    end

    always_ff @(posedge clk) begin
        if (rst || !en)                            pwm_out <= 1'b0;
        else if (period_hit)                       pwm_out <= (duty_new != '0);
        else if (pwm_out && count == duty_q - DW'(1)) pwm_out <= 1'b0;
    end
endmodule

// File: rtl/ccp_unit.sv
module ccp_unit
    import ccp_pkg::*;
#(
    parameter int TMR_W       = 16,
    parameter int DUTY_HI_W   = 8,
    parameter int DUTY_LO_W   = 2,
    parameter int SYNC_STAGES = 2,
    parameter int SMALL_DIV   = 4,
    parameter int BIG_DIV     = 16
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [TMR_W-1:0]       tmr_val,
    input  logic                   tmr_period_hit,
    input  logic                   ccp_in,
    input  logic                   wr_ctl,
    input  logic [DUTY_LO_W+3:0]   ctl_wdata,
    input  logic                   wr_val,
    input  logic [TMR_W-1:0]       val_wdata,
    input  logic                   flag_clr,
    output logic                   ccp_pin,
    output logic                   irq_flag,
    output logic                   tmr_reset_req,
    output logic                   special_evt,
    output logic [TMR_W-1:0]       cap_val
);
    localparam int DW = DUTY_HI_W + DUTY_LO_W;

    logic [3:0]           mode_q;
    logic [DUTY_LO_W-1:0] dcl_q;
    logic [TMR_W-1:0]     reg_q;
    ccp_dec_t             dec;
    ccp_dec_t             dec_new;
    logic                 wipe;
    logic                 presc_clr;
    logic                 rise, fall;
    logic                 cap_evt, match_evt;
    logic                 cmp_pin, pwm_pin, trig_q;

    assign dec       = decode_mode(mode_q);
    assign dec_new   = decode_mode(ctl_wdata[3:0]);
    assign wipe      = wr_ctl && (dec_new.kind == KIND_OFF);
    assign presc_clr = wipe || (wr_ctl && (ctl_wdata[3:0] != mode_q));

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= MODE_OFF;
            dcl_q  <= '0;
        end else if (wr_ctl) begin
            mode_q <= ctl_wdata[3:0];
            dcl_q  <= ctl_wdata[DUTY_LO_W+3:4];
        end
    end

    always_ff @(posedge clk) begin
        if (rst)         reg_q <= '0;
        else if (wr_val) reg_q <= val_wdata;
    end

    ccp_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .din(ccp_in), .rise(rise), .fall(fall)
    );

    ccp_capture #(.TMR_W(TMR_W), .SMALL_DIV(SMALL_DIV), .BIG_DIV(BIG_DIV)) u_cap (
        .clk(clk), .rst(rst), .presc_clr(presc_clr), .wipe(wipe),
        .en(dec.kind == KIND_CAP), .sel_fall(dec.cap_fall), .div(dec.div),
        .rise(rise), .fall(fall), .tmr_val(tmr_val),
        .cap_val(cap_val), .cap_evt(cap_evt)
    );

    ccp_compare #(.TMR_W(TMR_W)) u_cmp (
        .clk(clk), .rst(rst), .wipe(wipe), .en(dec.kind == KIND_CMP),
        .act(dec.act), .trig(dec.trig),
        .load_init(wr_ctl && dec_new.init_valid), .init_lvl(dec_new.init_lvl),
        .tmr_val(tmr_val), .cmp_val(reg_q),
        .pin(cmp_pin), .match_evt(match_evt), .trig_q(trig_q)
    );

    ccp_pwm #(.HI_W(DUTY_HI_W), .LO_W(DUTY_LO_W)) u_pwm (
        .clk(clk), .rst(rst), .en(dec.kind == KIND_PWM),
        .period_hit(tmr_period_hit), .tmr_lo(tmr_val[DUTY_HI_W-1:0]),
        .duty_new(DW'({reg_q[DUTY_HI_W-1:0], dcl_q})), .pwm_out(pwm_pin)
    );

    always_ff @(posedge clk) begin
        if (rst || wipe)                irq_flag <= 1'b0;
        else if (cap_evt || match_evt)  irq_flag <= 1'b1;
        else if (flag_clr)              irq_flag <= 1'b0;
    end

    always_comb begin
        case (dec.kind)
            KIND_CMP: ccp_pin = cmp_pin;
            KIND_PWM: ccp_pin = pwm_pin;
            default:  ccp_pin = 1'b0;
        endcase
    end

    assign tmr_reset_req = trig_q;
    assign special_evt   = trig_q;
endmodule

// File: rtl/ccp_unit_chk.sv
module ccp_unit_chk
    import ccp_pkg::*;
#(
    parameter int TMR_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             wr_ctl,
    input logic             flag_clr,
    input logic             tmr_period_hit,
    input logic             ccp_pin,
    input logic             irq_flag,
    input logic             tmr_reset_req,
    input logic [TMR_W-1:0] cap_val,
    input logic [3:0]       mode_q
);
    ccp_kind_e kind;
    assign kind = decode_mode(mode_q).kind;

    p_off_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        (kind == KIND_OFF) |-> (!ccp_pin && !irq_flag && cap_val == '0 && !tmr_reset_req));

    p_cap_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (kind != KIND_CAP && !wr_ctl) |=> $stable(cap_val));

    p_trig_single_r8: assert property (@(posedge clk) disable iff (rst)
        tmr_reset_req |=> !tmr_reset_req);

    p_flag_sticky_r10: assert property (@(posedge clk) disable iff (rst)
        (irq_flag && !flag_clr && !wr_ctl) |=> irq_flag);

    p_pwm_rise_r11: assert property (@(posedge clk) disable iff (rst)
        (kind == KIND_PWM && !wr_ctl && !tmr_period_hit && !ccp_pin) |=> !ccp_pin);
endmodule

bind ccp_unit ccp_unit_chk #(.TMR_W(TMR_W)) i_chk (
    .clk(clk), .rst(rst), .wr_ctl(wr_ctl), .flag_clr(flag_clr),
    .tmr_period_hit(tmr_period_hit), .ccp_pin(ccp_pin), .irq_flag(irq_flag),
    .tmr_reset_req(tmr_reset_req), .cap_val(cap_val), .mode_q(mode_q)
);

// File: tb/test_ccp_unit.sv
module test_ccp_unit;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] tmr_val = '0;
    logic        tmr_period_hit = 1'b0;
    logic        ccp_in = 1'b0;
    logic        wr_ctl = 1'b0;
    logic [5:0]  ctl_wdata = '0;
    logic        wr_val = 1'b0;
    logic [15:0] val_wdata = '0;
    logic        flag_clr = 1'b0;
    logic        ccp_pin, irq_flag, tmr_reset_req, special_evt;
    logic [15:0] cap_val;

    int n_tot = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    ccp_unit i_ccp_unit (
        .clk(clk), .rst(rst), .tmr_val(tmr_val), .tmr_period_hit(tmr_period_hit),
        .ccp_in(ccp_in), .wr_ctl(wr_ctl), .ctl_wdata(ctl_wdata),
        .wr_val(wr_val), .val_wdata(val_wdata), .flag_clr(flag_clr),
        .ccp_pin(ccp_pin), .irq_flag(irq_flag), .tmr_reset_req(tmr_reset_req),
        .special_evt(special_evt), .cap_val(cap_val)
    );

    // {mode[3:0], pulses[7:0], expected flag, expected capture}
    localparam logic [28:0] VEC [8] = '{
        {4'b0101, 8'd3,  1'b1, 16'h1002},
        {4'b0100, 8'd2,  1'b1, 16'h1001},
        {4'b0110, 8'd3,  1'b0, 16'h0000},
        {4'b0110, 8'd5,  1'b1, 16'h1003},
        {4'b0110, 8'd8,  1'b1, 16'h1007},
        {4'b0111, 8'd15, 1'b0, 16'h0000},
        {4'b0111, 8'd16, 1'b1, 16'h100F},
        {4'b0011, 8'd2,  1'b0, 16'h0000}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tot++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr_mode(input logic [3:0] m, input logic [1:0] dc);
        wr_ctl = 1'b1; ctl_wdata = {dc, m};
        @(negedge clk);
        wr_ctl = 1'b0;
    endtask

    task automatic wr_reg(input logic [15:0] v);
        wr_val = 1'b1; val_wdata = v;
        @(negedge clk);
        wr_val = 1'b0;
    endtask

    task automatic clr_flag();
        flag_clr = 1'b1;
        @(negedge clk);
        flag_clr = 1'b0;
    endtask

    task automatic pulse(input logic [15:0] v);
        tmr_val = v; ccp_in = 1'b1;
        tick(4);
        ccp_in = 1'b0;
        tick(4);
    endtask

    task automatic pwm_period(input int n, input logic do_wr, input logic [15:0] nv,
                              output int highs);
        highs = 0;
        for (int i = 0; i < n; i++) begin
            if (ccp_pin) highs++;
            tmr_val = 16'(i >> 2);
            tmr_period_hit = (i == n - 1);
            if (do_wr && i == 2) begin wr_val = 1'b1; val_wdata = nv; end
            else wr_val = 1'b0;
            @(negedge clk);
        end
        tmr_period_hit = 1'b0;
        wr_val = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_tot++; n_bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", n_tot, n_bad);
        $finish;
    end

    initial begin
        int h;
        tick(3);
        rst = 1'b0;
        tick(1);
        chk("R1 reset pin", 32'(ccp_pin), 32'd0);
        chk("R1 reset flag", 32'(irq_flag), 32'd0);
        chk("R1 reset cap", 32'(cap_val), 32'd0);
        chk("R1 reset trig", 32'({tmr_reset_req, special_evt}), 32'd0);

        // capture table: R2 edge choice, R3 prescale, R1 unused code
        for (int k = 0; k < 8; k++) begin
            logic [3:0] m;
            m = VEC[k][28:25];
            wr_mode(4'b0000, 2'b00);
            wr_mode(m, 2'b00);
            for (int p = 0; p < int'(VEC[k][24:17]); p++) pulse(16'h1000 + 16'(p));
            if (m == 4'b0110 || m == 4'b0111) begin
                chk("R3 capture value", 32'(cap_val), 32'(VEC[k][15:0]));
                chk("R3 capture flag (R10)", 32'(irq_flag), 32'(VEC[k][16]));
            end else if (m == 4'b0011) begin
                chk("R1 unused code capture", 32'(cap_val), 32'(VEC[k][15:0]));
                chk("R1 unused code flag", 32'(irq_flag), 32'(VEC[k][16]));
            end else begin
                chk("R2 capture value", 32'(cap_val), 32'(VEC[k][15:0]));
                chk("R2 capture flag (R10)", 32'(irq_flag), 32'(VEC[k][16]));
            end
        end

        // R1: writing 0000 clears capture and flag
        wr_mode(4'b0000, 2'b00);
        wr_mode(4'b0101, 2'b00);
        pulse(16'h3333);
        chk("R2 capture before wipe", 32'(cap_val), 32'h3333);
        wr_mode(4'b0000, 2'b00);
        chk("R1 wipe capture", 32'(cap_val), 32'd0);
        chk("R1 wipe flag", 32'(irq_flag), 32'd0);

        // R4: mode change restarts prescaler
        wr_mode(4'b0110, 2'b00);
        pulse(16'h2000); pulse(16'h2001);
        wr_mode(4'b0111, 2'b00);
        wr_mode(4'b0110, 2'b00);
        pulse(16'h2002); pulse(16'h2003); pulse(16'h2004);
        chk("R4 no capture after restart", 32'(cap_val), 32'd0);
        pulse(16'h2005);
        chk("R4 capture on fresh 4th edge", 32'(cap_val), 32'h2005);

        // compare modes
        wr_mode(4'b0000, 2'b00);
        wr_reg(16'h0050);
        tmr_val = 16'h0010;
        wr_mode(4'b1000, 2'b00);
        chk("R5 entry low", 32'(ccp_pin), 32'd0);
        tmr_val = 16'h0050; tick(1);
        chk("R5 match high", 32'(ccp_pin), 32'd1);
        chk("R10 match flag", 32'(irq_flag), 32'd1);
        chk("R8 no trig in 1000", 32'(tmr_reset_req), 32'd0);
        tmr_val = 16'h0010; tick(1);
        wr_mode(4'b1001, 2'b00);
        chk("R5 entry high", 32'(ccp_pin), 32'd1);
        clr_flag();
        chk("R10 flag cleared", 32'(irq_flag), 32'd0);
        tmr_val = 16'h0050; tick(1);
        chk("R5 match low", 32'(ccp_pin), 32'd0);
        chk("R10 flag set 1001", 32'(irq_flag), 32'd1);
        tmr_val = 16'h0010; tick(1);

        wr_mode(4'b0010, 2'b00);
        tmr_val = 16'h0050; tick(1);
        chk("R6 first toggle", 32'(ccp_pin), 32'd1);
        tick(3);
        chk("R9 held match toggles once", 32'(ccp_pin), 32'd1);
        tmr_val = 16'h0010; tick(1);
        tmr_val = 16'h0050; tick(1);
        chk("R6 second toggle", 32'(ccp_pin), 32'd0);
        tmr_val = 16'h0010; tick(1);
        tmr_val = 16'h0050; tick(1);
        tmr_val = 16'h0010; tick(1);
        chk("R6 third toggle", 32'(ccp_pin), 32'd1);

        wr_mode(4'b1010, 2'b00);
        clr_flag();
        tmr_val = 16'h0050; tick(1);
        chk("R7 pin untouched", 32'(ccp_pin), 32'd1);
        chk("R7 flag set", 32'(irq_flag), 32'd1);
        chk("R8 no trig in 1010", 32'({tmr_reset_req, special_evt}), 32'd0);
        tmr_val = 16'h0010; tick(1);

        wr_mode(4'b1011, 2'b00);
        clr_flag();
        tmr_val = 16'h0050; tick(1);
        chk("R8 trig pulse", 32'({tmr_reset_req, special_evt}), 32'h3);
        chk("R8 flag (R10)", 32'(irq_flag), 32'd1);
        tick(1);
        chk("R8 pulse one cycle", 32'({tmr_reset_req, special_evt}), 32'd0);
        tmr_val = 16'h0010; tick(1);

        wr_mode(4'b1101, 2'b00);
        chk("R1 unused code pin", 32'(ccp_pin), 32'd0);
        tmr_val = 16'h0050; tick(2);
        chk("R1 unused code no match", 32'({irq_flag, tmr_reset_req}), 32'd0);
        tmr_val = 16'h0010; tick(1);

        // PWM, period 64 cycles
        wr_reg(16'h0001);
        wr_mode(4'b1100, 2'b01);
        pwm_period(64, 1'b0, 16'h0, h);
        pwm_period(64, 1'b0, 16'h0, h);
        chk("R11 duty 5", 32'(h), 32'd5);
        pwm_period(64, 1'b1, 16'h0003, h);
        chk("R12 old duty kept", 32'(h), 32'd5);
        pwm_period(64, 1'b0, 16'h0, h);
        chk("R12 new duty 13", 32'(h), 32'd13);
        wr_reg(16'h0009);
        pwm_period(64, 1'b0, 16'h0, h);
        pwm_period(64, 1'b0, 16'h0, h);
        chk("R11 duty 37", 32'(h), 32'd37);
        wr_reg(16'h0000);
        wr_mode(4'b1100, 2'b00);
        pwm_period(64, 1'b0, 16'h0, h);
        pwm_period(64, 1'b0, 16'h0, h);
        chk("R13 duty zero", 32'(h), 32'd0);
        wr_reg(16'h00FF);
        wr_mode(4'b1100, 2'b11);
        pwm_period(64, 1'b0, 16'h0, h);
        pwm_period(64, 1'b0, 16'h0, h);
        chk("R13 duty saturates", 32'(h), 32'd64);

        $display("test done: total=%0d bad=%0d", n_tot, n_bad);
        $finish;
    end
endmodule